// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Data Cache

This block is a small data cache that sits between a processor load/store port and a slower main-memory port. Each line holds a single data word. A request address is cut into a byte offset, a set index and a tag. The four ways of the indexed set are compared in parallel, and the data of the matching way is steered out through a four-input selector.

Load misses stall the processor while the line is fetched from memory. The fetched word is written into the least recently used way of the set, with an empty way always taken first. Stores are write-through and do not allocate. A store that hits refreshes the cached word, and every store is posted to memory through a small FIFO write buffer. A full buffer holds back further stores.

A load miss reads memory only once the buffer has drained, so the fill can never return a value older than a store that is still queued.

Top module: `wt_assoc_cache`

## Requirements
- R1: The byte address is split into bits [1:0] as byte offset, bits [SET_W+1:2] as set index and the remaining upper bits as tag. Two addresses that differ only in the offset bits map to the same line.
- R2: A load hits when a valid way of the indexed set holds the request tag. A load hit raises cpu_rsp_valid with the stored word exactly one cycle after the request is accepted, and it issues no memory read.
- R3: After reset every line is invalid, so the first access to any address misses. Out of reset, cpu_req_ready is 1 and both cpu_rsp_valid and mem_req_valid are 0.
- R4: Each set keeps a recency order of its ways. Reset order from most to least recent is way 0, 1, 2, 3. A load hit, a store hit or a fill moves the touched way to the most recent place, and the ways that were ahead of it each move down one place.
- R5: A load miss issues one memory read (mem_req_write = 0) for the request address. The returned word is placed in the lowest-numbered invalid way, or in the least recent way if all four are valid. The word is returned on cpu_rsp_rdata one cycle after mem_rsp_valid.
- R6: A store that hits replaces the cached word. A later load of that address hits and returns the stored word.
- R7: Every accepted store is queued with its full address and data. The queue drains to memory as write requests (mem_req_write = 1), one per accepted memory request, in acceptance order.
- R8: A store that misses allocates no line. A later load of that address misses.
- R9: The write buffer holds WB_DEPTH entries (4 by default). While it is full, a store request sees cpu_req_ready = 0, but a load is still accepted.
- R10: A load miss issues its memory read only after the write buffer is empty.
- R11: A memory request that is not accepted is held: mem_req_valid stays high and mem_req_addr does not change until mem_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache accepts the request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = buffered store, 0 = line fill read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | DATA_W | Store data toward memory |
| mem_rsp_valid | input | 1 | Fill read data valid |
| mem_rsp_rdata | input | DATA_W | Fill read data |

## Verification
The bench builds the cache with SET_W = 2, which gives four sets, and keeps WB_DEPTH at 4. Eight tag values spread over four sets cause frequent conflicts, so every set fills all four ways and evicts lines many times. This exercises the recency order and the victim choice far more often than 256 sets would. With a four-entry buffer and a memory model that can be held not ready, the full-buffer stall and the fill that waits for the drain can each be reached in a few cycles.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE      = 2'd0,
        CTL_FILL_REQ  = 2'd1,
        CTL_FILL_WAIT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/wtc_ways.sv
module wtc_ways #(
    parameter int SET_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_data,
    output logic [WAYS-1:0]   lk_valid,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   match;

    // one comparator per way, all working on the same set
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    always_comb begin
        hit_way  = '0;
        hit_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way  = hit_way | WAY_W'(w);
                hit_data = hit_data | data_q[lk_set][w];
            end
        end
        hit      = |match;
        lk_valid = valid_q[lk_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2

endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
    parameter int SET_W = 8,
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] vic_set,
    input  logic [WAYS-1:0]  vic_valid,
    output logic [WAY_W-1:0] victim
);

    // position 0 = most recent, position WAYS-1 = least recent
    logic [WAY_W-1:0] order_q [SETS][WAYS];
    logic [WAY_W-1:0] row_d   [WAYS];

    always_comb begin
        logic found;
        found = 1'b0;
        for (int p = 0; p < WAYS; p++) begin
            if (found) begin
                row_d[p] = order_q[touch_set][p];
            end else begin
                row_d[p] = (p == 0) ? touch_way : order_q[touch_set][(p > 0) ? p - 1 : 0];
                if (order_q[touch_set][p] == touch_way) found = 1'b1;
            end
        end
    end

    always_comb begin
        victim = order_q[vic_set][WAYS-1];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vic_valid[w]) victim = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int p = 0; p < WAYS; p++)
                    order_q[s][p] <= WAY_W'(p);
        end else if (touch_en) begin
            for (int p = 0; p < WAYS; p++) order_q[touch_set][p] <= row_d[p];
        end
    end

    AST_MRU_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> order_q[$past(touch_set)][0] == $past(touch_way)); // R4

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push) f_d.wr = bump(f_q.wr);
        if (pop)  f_d.rd = bump(f_q.rd);
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
        empty     = (f_q.cnt == '0);
        full      = (f_q.cnt == CNT_W'(DEPTH));
        head_addr = addr_q[f_q.rd];
        head_data = data_q[f_q.rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[f_q.wr] <= push_addr;
            data_q[f_q.wr] <= push_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7

endmodule

// File: rtl/wt_assoc_cache.sv
module wt_assoc_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SET_W    = 8,
    parameter int WAYS     = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    localparam int OFF_W = 2;
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              accept, idle;
    logic [ADDR_W-1:0] lk_addr;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim;
    logic [DATA_W-1:0] hit_data;
    logic [WAYS-1:0]   lk_valid;
    logic              wr_en, touch_en;
    logic [WAY_W-1:0]  wr_way, touch_way;
    logic [DATA_W-1:0] wr_data;
    logic              wb_push, wb_pop, wb_empty, wb_full;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;

    always_comb begin
        c_d       = c_q;
        c_d.rsp_v = 1'b0;

        idle          = (c_q.st == CTL_IDLE);
        cpu_req_ready = idle && !(cpu_req_write && wb_full);
        accept        = cpu_req_valid && cpu_req_ready;
        lk_addr       = idle ? cpu_req_addr : c_q.addr;
        lk_set        = lk_addr[OFF_W +: SET_W];
        lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];

        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_data   = cpu_req_wdata;
        touch_en  = 1'b0;
        touch_way = hit_way;
        wb_push   = 1'b0;

        case (c_q.st)
            CTL_IDLE: begin
                if (accept) begin
                    if (cpu_req_write) begin
                        wb_push = 1'b1;
                        if (hit) begin
                            wr_en    = 1'b1;
                            touch_en = 1'b1;
                        end
                    end else if (hit) begin
                        c_d.rsp_v = 1'b1;
                        c_d.rsp_d = hit_data;
                        touch_en  = 1'b1;
                    end else begin
                        c_d.addr = cpu_req_addr;
                        c_d.st   = CTL_FILL_REQ;
                    end
                end
            end
            CTL_FILL_REQ: begin
                if (wb_empty && mem_req_ready) c_d.st = CTL_FILL_WAIT;
            end
            CTL_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    wr_en     = 1'b1;
                    wr_way    = victim;
                    wr_data   = mem_rsp_rdata;
                    touch_en  = 1'b1;
                    touch_way = victim;
                    c_d.rsp_v = 1'b1;
                    c_d.rsp_d = mem_rsp_rdata;
                    c_d.st    = CTL_IDLE;
                end
            end
            default: c_d.st = CTL_IDLE;
        endcase

        // the buffer owns the memory port until it is empty
        mem_req_valid = !wb_empty || (c_q.st == CTL_FILL_REQ);
        mem_req_write = !wb_empty;
        mem_req_addr  = wb_empty ? c_q.addr : wb_head_addr;
        mem_req_wdata = wb_head_data;
        wb_pop        = !wb_empty && mem_req_ready;

        cpu_rsp_valid = c_q.rsp_v;
        cpu_rsp_rdata = c_q.rsp_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: CTL_IDLE, addr: '0, rsp_v: 1'b0, rsp_d: '0};
        else        c_q <= c_d;
    end

    wtc_ways #(
        .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS)
    ) u_ways (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(lk_tag),
        .hit(hit), .hit_way(hit_way), .hit_data(hit_data), .lk_valid(lk_valid),
        .wr_en(wr_en), .wr_set(lk_set), .wr_way(wr_way), .wr_tag(lk_tag), .wr_data(wr_data)
    );

    wtc_lru #(
        .SET_W(SET_W), .WAYS(WAYS)
    ) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(lk_set), .touch_way(touch_way),
        .vic_set(lk_set), .vic_valid(lk_valid), .victim(victim)
    );

    wtc_wbuf #(
        .DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(wb_push), .push_addr(cpu_req_addr), .push_data(cpu_req_wdata),
        .pop(wb_pop), .head_addr(wb_head_addr), .head_data(wb_head_data),
        .empty(wb_empty), .full(wb_full)
    );

    AST_HIT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_req_write && hit |=> cpu_rsp_valid); // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
    AST_MISS_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_req_write && !hit |=> !cpu_rsp_valid); // R5

endmodule

// File: tb/sim_wt_assoc_cache.sv
module sim_wt_assoc_cache;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [AW-1:0] cpu_req_addr;
    logic [DW-1:0] cpu_req_wdata;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_req_valid, mem_req_ready, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_rdata;

    wt_assoc_cache #(.ADDR_W(AW), .DATA_W(DW), .SET_W(SW), .WAYS(4), .WB_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem    [32];
    logic [31:0] golden [32];
    logic [63:0] wq [$];
    bit          stall = 1'b0;
    bit          rd_pend = 1'b0;
    int          rd_dly = 0;
    logic [4:0]  rd_idx = '0;
    int          reads = 0;

    function automatic logic [31:0] init_word(input int i);
        return 32'hA500_0000 + i * 32'h0101_0101;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] = init_word(i);
        end else if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                logic [63:0] e;
                if (wq.size() == 0) begin
                    chk(1'b0, "R7 unexpected memory write", mem_req_addr, 32'h0);
                end else begin
                    e = wq.pop_front();
                    chk({mem_req_addr, mem_req_wdata} == e, "R7 write order addr", mem_req_addr, e[63:32]);
                end
                mem[mem_req_addr[6:2]] = mem_req_wdata;
            end else begin
                chk(wq.size() == 0, "R10 fill read with stores queued", wq.size(), 32'h0);
                reads++;
                rd_pend = 1'b1;
                rd_idx  = mem_req_addr[6:2];
                rd_dly  = $urandom_range(0, 3);
            end
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rd_pend) begin
            if (rd_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem[rd_idx];
                rd_pend = 1'b0;
            end else begin
                rd_dly--;
            end
        end
        mem_req_ready = stall ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    // ---------------- reference cache state ----------------
    bit m_valid [4][4];
    int m_tag   [4][4];
    int m_order [4][4];

    function automatic int model_lookup(input int s, input int t);
        for (int w = 0; w < 4; w++) if (m_valid[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void model_touch(input int s, input int w);
        int p;
        p = 3;
        for (int i = 0; i < 4; i++) if (m_order[s][i] == w) p = i;
        for (int i = p; i > 0; i--) m_order[s][i] = m_order[s][i-1];
        m_order[s][0] = w;
    endfunction

    function automatic int model_victim(input int s);
        for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return w;
        return m_order[s][3];
    endfunction

    function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
        return {25'b0, 3'(tag), 2'(set), 2'(off)};
    endfunction

    // one processor access, checked against the reference state
    task automatic do_op(input bit wr, input logic [31:0] addr, input logic [31:0] wd, output bit missed);
        int s, t, idx, way, r0, n, v;
        s   = int'(addr[3:2]);
        t   = int'(addr[6:4]);
        idx = int'(addr[6:2]);
        way = model_lookup(s, t);
        missed = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        r0 = reads;
        @(posedge clk);
        if (wr) begin
            wq.push_back({addr, wd});
            golden[idx] = wd;
            if (way >= 0) model_touch(s, way);
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (!wr) begin
            if (way >= 0) begin
                chk(cpu_rsp_valid, "R2 hit response one cycle after accept", 32'(cpu_rsp_valid), 32'h1);
                chk(cpu_rsp_rdata == golden[idx], "R2 hit data", cpu_rsp_rdata, golden[idx]);
                chk(reads == r0, "R2 hit issues no read", reads, r0);
                model_touch(s, way);
            end else begin
                missed = 1'b1;
                n = 0;
                while (!cpu_rsp_valid && n < 400) begin
                    @(negedge clk);
                    n++;
                end
                chk(cpu_rsp_valid, "R5 miss response", 32'(cpu_rsp_valid), 32'h1);
                chk(cpu_rsp_rdata == golden[idx], "R5 fill data", cpu_rsp_rdata, golden[idx]);
                chk(reads == r0 + 1, "R5 one fill read", reads, r0 + 1);
                v = model_victim(s);
                m_valid[s][v] = 1'b1;
                m_tag[s][v]   = t;
                model_touch(s, v);
            end
        end
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while (wq.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit m;
        int r;
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) golden[i] = init_word(i);
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++) begin
                m_valid[s][p] = 1'b0;
                m_tag[s][p]   = 0;
                m_order[s][p] = p;
            end
        rst_n = 1'b0;
        cpu_req_valid = 1'b0;
        cpu_req_write = 1'b0;
        cpu_req_addr  = '0;
        cpu_req_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        chk(cpu_req_ready == 1'b1, "R3 ready after reset", 32'(cpu_req_ready), 32'h1);
        chk(cpu_rsp_valid == 1'b0, "R3 no response after reset", 32'(cpu_rsp_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R3 no memory request after reset", 32'(mem_req_valid), 32'h0);
        do_op(1'b0, mk_addr(0, 0, 0), '0, m);
        chk(m, "R3 first access misses", 32'(m), 32'h1);

        // R1 offset bits ignored for lookup
        do_op(1'b0, mk_addr(0, 0, 3), '0, m);
        chk(!m, "R1 other offset hits same line", 32'(m), 32'h0);

        // R4 recency order: fill ways, retouch, then evict
        do_op(1'b0, mk_addr(1, 0, 0), '0, m);
        do_op(1'b0, mk_addr(2, 0, 0), '0, m);
        do_op(1'b0, mk_addr(3, 0, 0), '0, m);
        do_op(1'b0, mk_addr(0, 0, 0), '0, m);
        chk(!m, "R4 retouch hits", 32'(m), 32'h0);
        do_op(1'b0, mk_addr(4, 0, 0), '0, m);
        do_op(1'b0, mk_addr(0, 0, 0), '0, m);
        chk(!m, "R4 recent line kept", 32'(m), 32'h0);
        do_op(1'b0, mk_addr(1, 0, 0), '0, m);
        chk(m, "R4 least recent line evicted", 32'(m), 32'h1);

        // R6 store hit updates the line
        do_op(1'b1, mk_addr(0, 0, 0), 32'hDEAD_BEEF, m);
        do_op(1'b0, mk_addr(0, 0, 1), '0, m);
        chk(!m && cpu_rsp_rdata == 32'hDEAD_BEEF, "R6 store hit then load hit", cpu_rsp_rdata, 32'hDEAD_BEEF);

        // R8 store miss does not allocate
        do_op(1'b1, mk_addr(5, 1, 0), 32'h1234_5678, m);
        do_op(1'b0, mk_addr(5, 1, 0), '0, m);
        chk(m, "R8 store miss left line empty", 32'(m), 32'h1);

        // R9 full buffer stalls stores but not loads
        wait_drain();
        stall = 1'b1;
        for (int i = 0; i < 4; i++) do_op(1'b1, mk_addr(6, 2, 0), 32'h7700_0000 + i, m);
        do_op(1'b0, mk_addr(5, 1, 0), '0, m);
        chk(!m, "R9 load hit accepted with full buffer", 32'(m), 32'h0);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b1;
        cpu_req_addr  = mk_addr(7, 2, 0);
        cpu_req_wdata = 32'h5555_AAAA;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cpu_req_ready == 1'b0, "R9 store stalled while full", 32'(cpu_req_ready), 32'h0);
            chk(mem_req_valid && mem_req_write, "R11 drain request held", 32'(mem_req_valid), 32'h1);
        end
        cpu_req_valid = 1'b0;
        stall = 1'b0;
        wait_drain();
        chk(wq.size() == 0, "R7 buffer drained", wq.size(), 32'h0);

        // R10 load miss waits for the drain
        stall = 1'b1;
        do_op(1'b1, mk_addr(2, 3, 0), 32'hCAFE_0001, m);
        do_op(1'b1, mk_addr(3, 3, 0), 32'hCAFE_0002, m);
        r = reads;
        fork
            do_op(1'b0, mk_addr(3, 3, 0), '0, m);
            begin
                repeat (10) @(negedge clk);
                chk(reads == r, "R10 no fill read while stores queued", reads, r);
                stall = 1'b0;
            end
        join
        chk(m && cpu_rsp_rdata == 32'hCAFE_0002, "R10 fill sees drained store", cpu_rsp_rdata, 32'hCAFE_0002);

        // mixed random traffic
        for (int i = 0; i < 2500; i++) begin
            bit wr;
            wr = ($urandom_range(0, 9) < 4);
            do_op(wr, mk_addr($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3)),
                  $urandom, m);
        end

        wait_drain();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 32; i++)
            chk(mem[i] == golden[i], "R7 memory holds latest store", mem[i], golden[i]);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule